// File: doc/BRIEF.md
# Multichannel Bit-Serial FIR Filter

This block filters several independent sample streams with one shared arithmetic engine. Every channel has its own set of signed tap weights and its own history of past samples. The weights sit in a dual-ported weight memory. The sample history sits in a second memory that works as a circular buffer for each channel. When a sample is accepted, the engine works through the taps one at a time. For each tap it forms the weight-times-sample product bit-serially, one weight bit per clock, most significant bit first, using a doubling accumulator. A second accumulator adds the finished products. The final sum is rounded to nearest and clipped to the output width.

The engine takes one sample at a time. While a result is being computed, `busy` is high and any offered sample is dropped. A separate write port lets an outside agent load new weights at any time without stalling the engine. Each weight has two storage words. A write goes to the inactive word, and that word becomes active only while the engine is idle. A computation in progress therefore always sees a consistent set of weights.

Top module: `bsf_fir`

## Requirements
- R1: After reset, `busy` and `out_valid` are low and every channel's sample history is zero, so the first results of a channel depend only on the samples given since reset.
- R2: For a sample accepted on channel c, the result is the rounded and clipped value of the sum over k = 0..NTAP-1 of w[c][k]·x[c][n-k]. Here x[c][n] is the new sample, x[c][n-k] is that channel's k-th earlier accepted sample, and every channel's history is independent of the other channels.
- R3: Samples (DW bits) and weights (CW bits) are two's complement. The negative full-scale values -2^(DW-1) and -2^(CW-1) give exact products.
- R4: The output is floor((sum + 2^(SHR-1)) / 2^(SHR)), clipped to the range -2^(OW-1) .. 2^(OW-1)-1.
- R5: `out_valid` is high for exactly one cycle, NTAP·CW clock edges after the edge that accepted the sample. `busy` is high from the cycle after acceptance until that result appears.
- R6: A sample offered while `busy` is high is ignored. It is not stored in any history and produces no result.
- R7: `out_ch` carries the channel of the sample that produced the result, and results come out in the order the samples were accepted.
- R8: A weight write at (`wt_ch`, `wt_tap`), where tap k multiplies x[n-k], is used by every sample accepted in a later cycle than the write. It is not used by a sample accepted in the same cycle or earlier, even if the write lands while that sample is being computed.
- R9: Each channel's history holds exactly NTAP samples. A new sample displaces the oldest, and a sample stops contributing after NTAP newer samples of the same channel.
- R10: The sum accumulator never wraps. Worst-case inputs reach the clip limits instead of wrapping around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is offered this cycle |
| in_ch | input | CHW | Channel of the offered sample |
| in_data | input | DW | Signed sample value |
| busy | output | 1 | Engine is computing; offered samples are dropped |
| wt_we | input | 1 | Weight write strobe |
| wt_ch | input | CHW | Channel of the weight to write |
| wt_tap | input | TPW | Tap index of the weight to write |
| wt_data | input | CW | Signed weight value |
| out_valid | output | 1 | One-cycle result strobe |
| out_ch | output | CHW | Channel of the result |
| out_data | output | OW | Signed, rounded and clipped result |

## Verification
The hardest case to reach from the ports is a weight write that overlaps a computation, because the write is accepted without any stall. The overlap can happen while the sample is being accepted, in the middle of the run, or just before acceptance. The bench forces each of these cases. It drives a write in the same cycle as a sample, drives another a counted number of cycles into the run, and places a third one cycle before an acceptance. It then uses the following sample of the same channel to show whether the new weight has taken effect. Dropped samples are checked the same way: a sample is offered while `busy` is high, and the channel's next result must show a history that is unchanged.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bsf_state_e;

  // Slot of the k-th most recent sample in a ring of n entries, given a write
  // pointer that already points past the newest entry.
  function automatic int ring_slot(input int wp, input int k, input int n);
    return (wp + 2 * n - 1 - k) % n;
  endfunction

endpackage

// File: rtl/bsf_sequencer.sv
module bsf_sequencer
  import bsf_pkg::*;
#(
  parameter int NTAP = 4,
  parameter int CW   = 8,
  parameter int CHW  = 2,
  parameter int TPW  = 2,
  parameter int BW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [CHW-1:0] in_ch,
  output logic           accept,
  output logic           run,
  output logic           first_bit,
  output logic           last_bit,
  output logic           done,
  output logic [CHW-1:0] cur_ch,
  output logic [TPW-1:0] cur_tap,
  output logic [BW-1:0]  bit_idx,
  output logic           out_valid,
  output logic [CHW-1:0] out_ch
);

  localparam logic [BW-1:0]  BIT_TOP = BW'(CW - 1);
  localparam logic [TPW-1:0] TAP_END = TPW'(NTAP - 1);

  bsf_state_e     st_q;
  logic [TPW-1:0] tap_q;
  logic [BW-1:0]  bit_q;
  logic [CHW-1:0] ch_q;

  assign run       = (st_q == ST_RUN);
  assign accept    = !run && in_valid;
  assign first_bit = run && (bit_q == BIT_TOP);
  assign last_bit  = run && (bit_q == '0);
  assign done      = last_bit && (tap_q == TAP_END);
  assign cur_ch    = ch_q;
  assign cur_tap   = tap_q;
  assign bit_idx   = bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      tap_q     <= '0;
      bit_q     <= BIT_TOP;
      ch_q      <= '0;
      out_valid <= 1'b0;
      out_ch    <= '0;
    end else begin
      out_valid <= done;
      if (done) out_ch <= ch_q;
      if (accept) begin
        st_q  <= ST_RUN;
        ch_q  <= in_ch;
        tap_q <= '0;
        bit_q <= BIT_TOP;
      end else if (run) begin
        if (last_bit) begin
          bit_q <= BIT_TOP;
          if (done) st_q <= ST_IDLE;
          else      tap_q <= tap_q + 1'b1;
        end else begin
          bit_q <= bit_q - 1'b1;
        end
      end
    end
  end

  // R7: the channel tag of a computation cannot change under it
  assert_ch_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(ch_q));

  // R5: a result strobe lasts a single cycle
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

// File: rtl/bsf_coef_store.sv
module bsf_coef_store #(
  parameter int NCH  = 3,
  parameter int NTAP = 4,
  parameter int CW   = 8,
  parameter int CHW  = 2,
  parameter int TPW  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit_ok,
  input  logic                  wr_en,
  input  logic [CHW-1:0]        wr_ch,
  input  logic [TPW-1:0]        wr_tap,
  input  logic signed [CW-1:0]  wr_data,
  input  logic [CHW-1:0]        rd_ch,
  input  logic [TPW-1:0]        rd_tap,
  output logic signed [CW-1:0]  rd_data
);

  localparam int NE = NCH * NTAP;
  localparam int EW = (NE > 1) ? $clog2(NE) : 1;

  // two words per weight; sel picks the one the engine reads
  logic signed [CW-1:0] bank [2][NE];
  logic [NE-1:0] sel_q, pend_q, sel_eff;
  logic [EW-1:0] wr_e, rd_e;

  assign wr_e    = EW'(32'(wr_ch) * NTAP + 32'(wr_tap));
  assign rd_e    = EW'(32'(rd_ch) * NTAP + 32'(rd_tap));
  assign sel_eff = commit_ok ? (sel_q ^ pend_q) : sel_q;
  assign rd_data = bank[sel_q[rd_e]][rd_e];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      pend_q <= '0;
    end else begin
      sel_q  <= sel_eff;
      pend_q <= (commit_ok ? '0 : pend_q) | (wr_en ? (NE'(1) << wr_e) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) bank[~sel_eff[wr_e]][wr_e] <= wr_data;
  end

  // R8: the active word selection is frozen while a computation runs
  assert_sel_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ok |=> $stable(sel_q));

endmodule

// File: rtl/bsf_delay_line.sv
module bsf_delay_line
  import bsf_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int NTAP = 4,
  parameter int DW   = 8,
  parameter int CHW  = 2,
  parameter int TPW  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic [CHW-1:0]       push_ch,
  input  logic signed [DW-1:0] push_data,
  input  logic [CHW-1:0]       rd_ch,
  input  logic [TPW-1:0]       rd_tap,
  output logic signed [DW-1:0] rd_data
);

  localparam int NE = NCH * NTAP;
  localparam int EW = (NE > 1) ? $clog2(NE) : 1;
  localparam logic [TPW-1:0] WP_END = TPW'(NTAP - 1);

  logic signed [DW-1:0] mem [NE];
  logic [TPW-1:0] wp_q [NCH];
  logic [TPW-1:0] rd_slot;
  logic [EW-1:0]  push_e, rd_e;

  assign push_e  = EW'(32'(push_ch) * NTAP + 32'(wp_q[push_ch]));
  assign rd_slot = TPW'(ring_slot(32'(wp_q[rd_ch]), 32'(rd_tap), NTAP));
  assign rd_e    = EW'(32'(rd_ch) * NTAP + 32'(rd_slot));
  assign rd_data = mem[rd_e];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) mem[i] <= '0;
      for (int c = 0; c < NCH; c++) wp_q[c] <= '0;
    end else if (push) begin
      mem[push_e]   <= push_data;
      wp_q[push_ch] <= (wp_q[push_ch] == WP_END) ? '0 : wp_q[push_ch] + 1'b1;
    end
  end

endmodule

// File: rtl/bsf_mac.sv
module bsf_mac #(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int NTAP = 4,
  parameter int OW   = 10,
  parameter int SHR  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 run,
  input  logic                 first_bit,
  input  logic                 last_bit,
  input  logic                 done,
  input  logic                 wbit,
  input  logic signed [DW-1:0] samp,
  output logic signed [OW-1:0] y
);

  localparam int PW = DW + CW;
  localparam int SW = PW + ((NTAP > 1) ? $clog2(NTAP) : 1);
  localparam int QW = SW + 1 - SHR;
  localparam logic signed [QW-1:0] QMAX = QW'((2 ** (OW - 1)) - 1);
  localparam logic signed [QW-1:0] QMIN = ~QMAX;

  // round half up by dropping SHR bits, then clip to OW bits
  function automatic logic signed [OW-1:0] round_sat(input logic signed [SW-1:0] v);
    logic signed [SW:0]   r;
    logic signed [QW-1:0] q;
    r = {v[SW-1], v} + (SW + 1)'(2 ** (SHR - 1));
    q = r[SW:SHR];
    if (q > QMAX) return QMAX[OW-1:0];
    if (q < QMIN) return QMIN[OW-1:0];
    return q[OW-1:0];
  endfunction

  logic signed [PW-1:0] samp_x, prod_q, prod_nx;
  logic signed [SW-1:0] sum_q, sum_nx;
  logic signed [SW:0]   sum_wide;

  assign samp_x = {{CW{samp[DW-1]}}, samp};

  always_comb begin
    if (first_bit) prod_nx = wbit ? -samp_x : '0;
    else           prod_nx = (prod_q <<< 1) + (wbit ? samp_x : '0);
    sum_wide = {sum_q[SW-1], sum_q} + {{(SW + 1 - PW){prod_nx[PW-1]}}, prod_nx};
    sum_nx   = sum_wide[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      sum_q  <= '0;
      y      <= '0;
    end else begin
      if (run) prod_q <= prod_nx;
      if (start) sum_q <= '0;
      else if (last_bit) sum_q <= sum_nx;
      if (done) y <= round_sat(sum_nx);
    end
  end

  // R10: adding a finished product never leaves the sum range
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |-> (sum_wide[SW] == sum_wide[SW-1]));

endmodule

// File: rtl/bsf_fir.sv
module bsf_fir #(
  parameter int NCH  = 3,
  parameter int NTAP = 4,
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int OW   = 10,
  parameter int SHR  = 6,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TPW = (NTAP > 1) ? $clog2(NTAP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [CHW-1:0]       in_ch,
  input  logic signed [DW-1:0] in_data,
  output logic                 busy,
  input  logic                 wt_we,
  input  logic [CHW-1:0]       wt_ch,
  input  logic [TPW-1:0]       wt_tap,
  input  logic signed [CW-1:0] wt_data,
  output logic                 out_valid,
  output logic [CHW-1:0]       out_ch,
  output logic signed [OW-1:0] out_data
);

  localparam int BW   = (CW > 1) ? $clog2(CW) : 1;
  localparam int NCYC = NTAP * CW;
  localparam int CNTW = $clog2(NCYC + 1);

  logic accept, run, first_bit, last_bit, done;
  logic [CHW-1:0] cur_ch;
  logic [TPW-1:0] cur_tap;
  logic [BW-1:0]  bit_idx;
  logic signed [CW-1:0] wt_word;
  logic signed [DW-1:0] hist_word;

  assign busy = run;

  bsf_sequencer #(.NTAP(NTAP), .CW(CW), .CHW(CHW), .TPW(TPW), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
    .accept(accept), .run(run), .first_bit(first_bit), .last_bit(last_bit),
    .done(done), .cur_ch(cur_ch), .cur_tap(cur_tap), .bit_idx(bit_idx),
    .out_valid(out_valid), .out_ch(out_ch)
  );

  bsf_coef_store #(.NCH(NCH), .NTAP(NTAP), .CW(CW), .CHW(CHW), .TPW(TPW)) u_wt (
    .clk(clk), .rst_n(rst_n), .commit_ok(!run),
    .wr_en(wt_we), .wr_ch(wt_ch), .wr_tap(wt_tap), .wr_data(wt_data),
    .rd_ch(cur_ch), .rd_tap(cur_tap), .rd_data(wt_word)
  );

  bsf_delay_line #(.NCH(NCH), .NTAP(NTAP), .DW(DW), .CHW(CHW), .TPW(TPW)) u_hist (
    .clk(clk), .rst_n(rst_n), .push(accept), .push_ch(in_ch), .push_data(in_data),
    .rd_ch(cur_ch), .rd_tap(cur_tap), .rd_data(hist_word)
  );

  bsf_mac #(.DW(DW), .CW(CW), .NTAP(NTAP), .OW(OW), .SHR(SHR)) u_mac (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(run), .first_bit(first_bit),
    .last_bit(last_bit), .done(done), .wbit(wt_word[bit_idx]), .samp(hist_word),
    .y(out_data)
  );

  // busy-cycle counter observed by the latency property
  logic [CNTW-1:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (accept) busy_cnt <= '0;
    else if (run)    busy_cnt <= busy_cnt + 1'b1;
  end

  // R5: a result appears after exactly NTAP*CW busy cycles
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (busy_cnt == CNTW'(NCYC)));

  // R6: the engine only becomes busy because a sample was offered
  assert_busy_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid));

endmodule

// File: tb/sim_bsf_fir.sv
module sim_bsf_fir;

  localparam int NCH  = 3;
  localparam int NTAP = 4;
  localparam int DW   = 8;
  localparam int CW   = 8;
  localparam int OW   = 10;
  localparam int SHR  = 6;
  localparam int CHW  = 2;
  localparam int TPW  = 2;
  localparam int NCYC = NTAP * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [CHW-1:0] in_ch = '0;
  logic signed [DW-1:0] in_data = '0;
  logic wt_we = 1'b0;
  logic [CHW-1:0] wt_ch = '0;
  logic [TPW-1:0] wt_tap = '0;
  logic signed [CW-1:0] wt_data = '0;
  logic busy, out_valid;
  logic [CHW-1:0] out_ch;
  logic signed [OW-1:0] out_data;

  always #2 clk = ~clk;

  bsf_fir #(.NCH(NCH), .NTAP(NTAP), .DW(DW), .CW(CW), .OW(OW), .SHR(SHR)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
    .busy(busy), .wt_we(wt_we), .wt_ch(wt_ch), .wt_tap(wt_tap), .wt_data(wt_data),
    .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
  );

  int n_checks = 0;
  int n_err = 0;
  int wts [NCH][NTAP];
  int hist [NCH][NTAP];
  int exp_y;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int model_y(input int ch);
    int s, t, q, d, hi, lo;
    s = 0;
    for (int k = 0; k < NTAP; k++) s += wts[ch][k] * hist[ch][k];
    d = 1 << SHR;
    t = s + d / 2;
    if (t >= 0) q = t / d;
    else        q = -((-t + d - 1) / d);
    hi = (1 << (OW - 1)) - 1;
    lo = -(1 << (OW - 1));
    if (q > hi) q = hi;
    if (q < lo) q = lo;
    return q;
  endfunction

  // idle-time or mid-run weight write, one cycle, entered at a falling edge
  task automatic wwrite(input int ch, input int k, input int v);
    wt_we = 1'b1; wt_ch = CHW'(ch); wt_tap = TPW'(k); wt_data = CW'(v);
    @(negedge clk);
    wt_we = 1'b0;
    wts[ch][k] = v;
  endtask

  // offer a sample once idle; optionally a weight write in the same cycle
  task automatic start_sample(input int ch, input int x, input bit wr, input int wk, input int wv);
    while (busy) @(negedge clk);
    for (int k = NTAP - 1; k > 0; k--) hist[ch][k] = hist[ch][k-1];
    hist[ch][0] = x;
    exp_y = model_y(ch);
    in_valid = 1'b1; in_ch = CHW'(ch); in_data = DW'(x);
    if (wr) begin
      wt_we = 1'b1; wt_ch = CHW'(ch); wt_tap = TPW'(wk); wt_data = CW'(wv);
    end
    @(negedge clk);
    in_valid = 1'b0;
    wt_we = 1'b0;
    if (wr) wts[ch][wk] = wv;
    chk(busy == 1'b1, "R5 busy after accept", int'(busy), 1);
  endtask

  task automatic finish_sample(input int ch, input int elapsed, input string tag);
    for (int m = elapsed + 1; m <= NCYC; m++) begin
      @(negedge clk);
      if (m == NCYC - 1) chk(out_valid == 1'b0, "R5 no early result", int'(out_valid), 0);
    end
    chk(out_valid == 1'b1, "R5 result strobe", int'(out_valid), 1);
    chk(int'(out_ch) == ch, "R7 result channel", int'(out_ch), ch);
    chk(int'(out_data) == exp_y, tag, int'(out_data), exp_y);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 strobe one cycle", int'(out_valid), 0);
  endtask

  task automatic run_sample(input int ch, input int x, input string tag);
    start_sample(ch, x, 1'b0, 0, 0);
    finish_sample(ch, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL watchdog: got %0d expected %0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NTAP; k++) begin
        wts[c][k] = 0;
        hist[c][k] = 0;
      end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

    wwrite(0, 0, 3);    wwrite(0, 1, -5);  wwrite(0, 2, 7);   wwrite(0, 3, 2);
    wwrite(1, 0, -128); wwrite(1, 1, 64);  wwrite(1, 2, -1);  wwrite(1, 3, 1);
    wwrite(2, 0, 90);   wwrite(2, 1, -33); wwrite(2, 2, 127); wwrite(2, 3, -100);
    @(negedge clk);

    // R1: first results see an empty history
    run_sample(0, 50, "R1 first result ch0");
    run_sample(2, -77, "R1 first result ch2");

    // R2 / R7 / R9: interleaved sweep across channels and sample values
    for (int i = 0; i < 42; i++) begin
      run_sample(i % NCH, ((i * 53 + 17) % 256) - 128, "R2 sweep value");
    end

    // R3: negative full-scale weight and sample
    run_sample(1, -128, "R3 full-scale negative");
    run_sample(1, 127, "R3 full-scale positive");
    run_sample(1, -128, "R3 full-scale again");

    // R4: rounding boundaries with a single unit weight on tap 0
    wwrite(2, 0, 1); wwrite(2, 1, 0); wwrite(2, 2, 0); wwrite(2, 3, 0);
    run_sample(2, 32, "R4 round +half up");
    run_sample(2, 31, "R4 round below half");
    run_sample(2, -32, "R4 round -half up");
    run_sample(2, -33, "R4 round below -half");

    // R9: only the oldest tap weighted; sample leaves after NTAP newer ones
    wwrite(2, 0, 0); wwrite(2, 3, 64);
    for (int i = 1; i <= 6; i++) run_sample(2, 10 * i, "R9 ring depth");

    // R10: worst-case sums clip instead of wrapping
    for (int k = 0; k < NTAP; k++) wwrite(2, k, -128);
    for (int i = 0; i < NTAP; i++) run_sample(2, -128, "R10 positive clip");
    for (int k = 0; k < NTAP; k++) wwrite(2, k, 127);
    run_sample(2, -128, "R10 negative clip");

    // R6: sample offered while busy is dropped
    start_sample(0, 40, 1'b0, 0, 0);
    in_valid = 1'b1; in_ch = 2'd0; in_data = DW'(111);
    @(negedge clk);
    in_valid = 1'b0;
    finish_sample(0, 1, "R6 result while dropped");
    run_sample(0, -9, "R6 history untouched");

    // R8: write landing mid-run is not used until the next sample
    start_sample(1, 55, 1'b0, 0, 0);
    repeat (5) @(negedge clk);
    wwrite(1, 3, 100);
    finish_sample(1, 6, "R8 mid-run write unused");
    run_sample(1, -20, "R8 mid-run write used next");

    // R8: write in the acceptance cycle is not used by that sample
    start_sample(1, 33, 1'b1, 0, -7);
    exp_y = exp_y;
    finish_sample(1, 0, "R8 same-cycle write unused");
    run_sample(1, 12, "R8 same-cycle write used next");

    // R8: write one cycle before acceptance is used
    wwrite(1, 1, -90);
    run_sample(1, 70, "R8 earlier write used");

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule